// File: doc/BRIEF.md
# SDRAM Command Decoder and Power-State Tracker

This block sits on the device side of a synchronous DRAM interface, in a bus monitor or in the front end of a behavioural memory model. On every rising clock edge it samples the clock-enable pin, the select, row-strobe, column-strobe and write-enable pins, the bank number and two address bits. From these it reports which command was issued, as a one-hot vector. It also tracks which banks hold an open row and which power state the device is in. A command that the current state does not permit raises a flag and has no effect.

The clock-enable value from the previous edge is held inside the block, and the command is decoded from the pair. The same pin code with the clock enable high on both edges is an auto refresh. With the clock enable high on the previous edge and low on the current edge, that code enters self refresh. A quiet cycle with the clock enable falling enters power-down when every bank is closed and clock suspend when a row is open. A burst-advance enable passes through the block and is held low for as long as the device is suspended.

After a self-refresh exit the device needs a programmable number of cycles before it accepts a real command. After a power-down exit it needs a second, separate count. Any command other than a no-operation or deselect during that window is flagged.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While `rst` is high, and after it, until the first decoded edge, `cmd_o` holds only bit 0 (no-operation). `pstate_o` is 0, and `illegal_o`, `bank_open_o`, `rd_burst_wr_single_o` and `burst_adv_o` are all 0. Every output is registered and changes one edge after the inputs it reflects.
- R2: The previous and current clock enable are both high, the state is normal (0) and the select is low. The 3-bit code {row_strobe_n, col_strobe_n, write_en_n} then decodes as follows: 000 is mode write (bit 1), 001 is auto refresh (bit 7), 010 is precharge (bit 5), 011 is activate (bit 2), 100 is write (bit 4), 101 is read (bit 3), 110 is burst stop (bit 6) and 111 is no-operation (bit 0).
- R3: With `chip_sel_n` high, the code is treated as no-operation (bit 0) whatever the three strobes are.
- R4: In the normal state with the previous-edge clock enable low, no command is decoded. `cmd_o` shows hold (bit 12). The flip-flop holding that previous value resets to 0.
- R5: The clock enable falls while the code is 001. With all banks closed this is self-refresh entry (bit 8) and `pstate_o` becomes 3. With any bank open it is illegal.
- R6: The clock enable falls with a quiet code (no-operation or deselect). With all banks closed this is power-down entry (bit 9, state 1). With any bank open it is clock-suspend entry (bit 10, state 2). The clock enable falls with any other code except 001: with a bank open this is suspend entry, and with all banks closed it is illegal.
- R7: In state 1 or 3, the clock enable high with a quiet code exits to normal (bit 11). The clock enable high with any other code is illegal and the state is kept. In state 2, the clock enable high exits to normal. In states 1, 2 and 3, the clock enable low gives hold (bit 12) and keeps the state.
- R8: After an exit from state 3, the next `SREF_EXIT_CYC` edges reject every code that is not quiet. After an exit from state 1, the next `PDN_EXIT_CYC` edges do the same. Quiet codes are accepted in the window. After an exit from state 2 there is no window.
- R9: Activate opens the bank on `bank_i`. Precharge with `ap_flag_i` high closes every bank, and with `ap_flag_i` low closes only the addressed bank. Read or write with `ap_flag_i` high closes the addressed bank on the same edge.
- R10: In the normal state the following are illegal: activate to an open bank, read or write to a closed bank, and mode write or auto refresh while any bank is open. An illegal command sets `illegal_o`, sets no bit of `cmd_o`, and changes neither the banks, the state nor the mode flag.
- R11: An accepted mode write loads `rd_burst_wr_single_o` from `wr_mode_bit_i`. A 1 selects bursts for reads with single-beat writes.
- R12: `burst_adv_o` follows `burst_adv_i` one edge later. It is forced to 0 from the suspend-entry edge until the exit edge.
- R13: After every edge, exactly one of these holds: one bit of `cmd_o` is set, or `illegal_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock-enable pin of the memory |
| chip_sel_n | input | 1 | Active-low select |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| write_en_n | input | 1 | Active-low write enable |
| bank_i | input | $clog2(NUM_BANKS) | Bank number |
| ap_flag_i | input | 1 | Address bit for all-bank precharge or auto-precharge |
| wr_mode_bit_i | input | 1 | Address bit selecting the write-burst mode on a mode write |
| burst_adv_i | input | 1 | External burst-advance enable |
| cmd_o | output | 13 | One-hot decoded command |
| pstate_o | output | 2 | Power state: 0 normal, 1 power-down, 2 suspend, 3 self refresh |
| illegal_o | output | 1 | Command rejected for the current state |
| bank_open_o | output | NUM_BANKS | Open-row flag per bank |
| rd_burst_wr_single_o | output | 1 | Burst-read single-write mode flag |
| burst_adv_o | output | 1 | Burst-advance enable, frozen during suspend |

## Verification
The hardest situation to reach is a real command inside the exit window. The window opens only after the device has gone idle and entered self refresh or power-down, and has then left it with a quiet code. The stimulus precharges every bank, enters self refresh, holds it, exits with a deselect, and then issues activates on every edge of the window. It also issues a clean exit followed only by no-operations, which shows where the window ends. A further awkward case is a wrong exit attempt: the clock enable rises with a real command while the device is powered down. This leaves the previous clock enable high inside a low-power state. The bench produces it and then exits correctly on the next edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    PS_NORMAL  = 2'd0,
    PS_PDOWN   = 2'd1,
    PS_SUSPEND = 2'd2,
    PS_SELFREF = 2'd3
  } pstate_e;

  // pin code {row_strobe_n, col_strobe_n, write_en_n}
  localparam logic [2:0] OP_MODE = 3'b000;
  localparam logic [2:0] OP_AREF = 3'b001;
  localparam logic [2:0] OP_PRE  = 3'b010;
  localparam logic [2:0] OP_ACT  = 3'b011;
  localparam logic [2:0] OP_WR   = 3'b100;
  localparam logic [2:0] OP_RD   = 3'b101;
  localparam logic [2:0] OP_BST  = 3'b110;
  localparam logic [2:0] OP_NOP  = 3'b111;

  // one-hot command vector positions
  localparam int C_NOP  = 0;
  localparam int C_MRS  = 1;
  localparam int C_ACT  = 2;
  localparam int C_RD   = 3;
  localparam int C_WR   = 4;
  localparam int C_PRE  = 5;
  localparam int C_BST  = 6;
  localparam int C_AREF = 7;
  localparam int C_SREF = 8;
  localparam int C_PDN  = 9;
  localparam int C_SUSP = 10;
  localparam int C_EXIT = 11;
  localparam int C_HOLD = 12;
  localparam int CMD_N  = 13;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
(
  input  logic             cke_prev,
  input  logic             cke,
  input  logic             sel_n,
  input  logic [2:0]       op,
  input  logic             bank_hit,
  input  logic             any_open,
  input  logic             wait_busy,
  input  pstate_e          cur_st,
  output logic [CMD_N-1:0] cmd,
  output logic             bad,
  output pstate_e          nxt_st
);

  logic quiet;
  assign quiet = sel_n || (op == OP_NOP);

  always_comb begin
    cmd    = '0;
    bad    = 1'b0;
    nxt_st = cur_st;
    case (cur_st)
      PS_NORMAL: begin
        if (!cke_prev) begin
          cmd[C_HOLD] = 1'b1;
        end else if (wait_busy && !quiet) begin
          bad = 1'b1;
        end else if (!cke) begin
          if (quiet) begin
            if (any_open) begin
              cmd[C_SUSP] = 1'b1;
              nxt_st      = PS_SUSPEND;
            end else begin
              cmd[C_PDN] = 1'b1;
              nxt_st     = PS_PDOWN;
            end
          end else if (op == OP_AREF) begin
            if (any_open) bad = 1'b1;
            else begin
              cmd[C_SREF] = 1'b1;
              nxt_st      = PS_SELFREF;
            end
          end else if (any_open) begin
            cmd[C_SUSP] = 1'b1;
            nxt_st      = PS_SUSPEND;
          end else begin
            bad = 1'b1;
          end
        end else if (quiet) begin
          cmd[C_NOP] = 1'b1;
        end else begin
          case (op)
            OP_MODE: if (any_open) bad = 1'b1; else cmd[C_MRS] = 1'b1;
            OP_AREF: if (any_open) bad = 1'b1; else cmd[C_AREF] = 1'b1;
            OP_PRE:  cmd[C_PRE] = 1'b1;
            OP_ACT:  if (bank_hit) bad = 1'b1; else cmd[C_ACT] = 1'b1;
            OP_WR:   if (bank_hit) cmd[C_WR] = 1'b1; else bad = 1'b1;
            OP_RD:   if (bank_hit) cmd[C_RD] = 1'b1; else bad = 1'b1;
            OP_BST:  cmd[C_BST] = 1'b1;
            default: cmd[C_NOP] = 1'b1;
          endcase
        end
      end
      PS_PDOWN, PS_SELFREF: begin
        if (!cke) begin
          cmd[C_HOLD] = 1'b1;
        end else if (quiet) begin
          cmd[C_EXIT] = 1'b1;
          nxt_st      = PS_NORMAL;
        end else begin
          bad = 1'b1;
        end
      end
      default: begin
        if (!cke) begin
          cmd[C_HOLD] = 1'b1;
        end else begin
          cmd[C_EXIT] = 1'b1;
          nxt_st      = PS_NORMAL;
        end
      end
    endcase
  end

endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 do_act,
  input  logic                 do_pre,
  input  logic                 do_rw,
  input  logic                 ap,
  input  logic [BA_W-1:0]      ba,
  output logic [NUM_BANKS-1:0] open_q
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[g] <= 1'b0;
      end else if (do_act && sel) begin
        open_q[g] <= 1'b1;
      end else if ((do_pre && (ap || sel)) || (do_rw && ap && sel)) begin
        open_q[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdc_exit_timer.sv
module sdc_exit_timer #(
  parameter int SREF_EXIT_CYC = 9,
  parameter int PDN_EXIT_CYC  = 1,
  localparam int WMAX = (SREF_EXIT_CYC > PDN_EXIT_CYC) ?
                        ((SREF_EXIT_CYC > 1) ? SREF_EXIT_CYC : 1) :
                        ((PDN_EXIT_CYC > 1) ? PDN_EXIT_CYC : 1),
  localparam int CNT_W = $clog2(WMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic exit_go,
  input  logic from_sref,
  input  logic from_pdn,
  output logic busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (exit_go) begin
      if (from_sref)     cnt_q <= CNT_W'(SREF_EXIT_CYC);
      else if (from_pdn) cnt_q <= CNT_W'(PDN_EXIT_CYC);
      else               cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int SREF_EXIT_CYC = 9,
  parameter int PDN_EXIT_CYC  = 1,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en,
  input  logic                 chip_sel_n,
  input  logic                 row_strobe_n,
  input  logic                 col_strobe_n,
  input  logic                 write_en_n,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 ap_flag_i,
  input  logic                 wr_mode_bit_i,
  input  logic                 burst_adv_i,
  output logic [CMD_N-1:0]     cmd_o,
  output logic [1:0]           pstate_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 rd_burst_wr_single_o,
  output logic                 burst_adv_o
);

  pstate_e          st_q, st_nxt;
  logic             cke_q;
  logic [CMD_N-1:0] dec_cmd, cmd_q;
  logic             dec_bad, ill_q, mode_q, adv_q, wait_busy;
  logic [NUM_BANKS-1:0] open_q;

  sdc_cmd_decode u_dec (
    .cke_prev  (cke_q),
    .cke       (clk_en),
    .sel_n     (chip_sel_n),
    .op        ({row_strobe_n, col_strobe_n, write_en_n}),
    .bank_hit  (open_q[bank_i]),
    .any_open  (|open_q),
    .wait_busy (wait_busy),
    .cur_st    (st_q),
    .cmd       (dec_cmd),
    .bad       (dec_bad),
    .nxt_st    (st_nxt)
  );

  sdc_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk    (clk),
    .rst    (rst),
    .do_act (dec_cmd[C_ACT]),
    .do_pre (dec_cmd[C_PRE]),
    .do_rw  (dec_cmd[C_RD] | dec_cmd[C_WR]),
    .ap     (ap_flag_i),
    .ba     (bank_i),
    .open_q (open_q)
  );

  sdc_exit_timer #(
    .SREF_EXIT_CYC (SREF_EXIT_CYC),
    .PDN_EXIT_CYC  (PDN_EXIT_CYC)
  ) u_wait (
    .clk       (clk),
    .rst       (rst),
    .exit_go   (dec_cmd[C_EXIT]),
    .from_sref (st_q == PS_SELFREF),
    .from_pdn  (st_q == PS_PDOWN),
    .busy      (wait_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_NORMAL;
      cke_q  <= 1'b0;
      cmd_q  <= CMD_N'(1);
      ill_q  <= 1'b0;
      mode_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      cke_q  <= clk_en;
      cmd_q  <= dec_cmd;
      ill_q  <= dec_bad;
      if (dec_cmd[C_MRS]) mode_q <= wr_mode_bit_i;
      adv_q  <= burst_adv_i && (st_nxt != PS_SUSPEND);
    end
  end

  assign cmd_o                = cmd_q;
  assign pstate_o             = st_q;
  assign illegal_o            = ill_q;
  assign bank_open_o          = open_q;
  assign rd_burst_wr_single_o = mode_q;
  assign burst_adv_o          = adv_q;

endmodule

// File: rtl/sdc_tracker_chk.sv
module sdc_tracker_chk
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int SREF_EXIT_CYC = 9,
  parameter int PDN_EXIT_CYC  = 1,
  localparam int WMAX = (SREF_EXIT_CYC > PDN_EXIT_CYC) ?
                        ((SREF_EXIT_CYC > 1) ? SREF_EXIT_CYC : 1) :
                        ((PDN_EXIT_CYC > 1) ? PDN_EXIT_CYC : 1),
  localparam int W_W = $clog2(WMAX + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clk_en,
  input logic                 chip_sel_n,
  input logic                 row_strobe_n,
  input logic                 col_strobe_n,
  input logic                 write_en_n,
  input logic [CMD_N-1:0]     cmd_o,
  input logic [1:0]           pstate_o,
  input logic                 illegal_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 burst_adv_o
);

  logic           ck_q;
  logic           quiet;
  logic [W_W-1:0] win_q;

  assign quiet = chip_sel_n || ({row_strobe_n, col_strobe_n, write_en_n} == OP_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q  <= 1'b0;
      win_q <= '0;
    end else begin
      ck_q <= clk_en;
      if (pstate_o == 2'd3 && clk_en && quiet)      win_q <= W_W'(SREF_EXIT_CYC);
      else if (pstate_o == 2'd1 && clk_en && quiet) win_q <= W_W'(PDN_EXIT_CYC);
      else if (win_q != '0)                         win_q <= win_q - 1'b1;
    end
  end

  p_one_result_r13: assert property (@(posedge clk) disable iff (rst)
    ($countones(cmd_o) + int'(illegal_o)) == 1);

  p_deselect_nop_r3: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 2'd0 && ck_q && clk_en && chip_sel_n) |=> cmd_o[C_NOP]);

  p_sref_state_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_o[C_SREF] |-> (pstate_o == 2'd3 && bank_open_o == '0));

  p_pdn_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_o[C_PDN] |-> (pstate_o == 2'd1 && bank_open_o == '0));

  p_low_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (pstate_o != 2'd0 && !clk_en) |=> (cmd_o[C_HOLD] && $stable(pstate_o)));

  p_exit_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (win_q != '0 && pstate_o == 2'd0 && ck_q && !quiet) |=> illegal_o);

  p_reject_no_effect_r10: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (bank_open_o == $past(bank_open_o)));

  p_adv_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 2'd2) |-> !burst_adv_o);

endmodule

bind sdram_cmd_tracker sdc_tracker_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .SREF_EXIT_CYC (SREF_EXIT_CYC),
  .PDN_EXIT_CYC  (PDN_EXIT_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clk_en       (clk_en),
  .chip_sel_n   (chip_sel_n),
  .row_strobe_n (row_strobe_n),
  .col_strobe_n (col_strobe_n),
  .write_en_n   (write_en_n),
  .cmd_o        (cmd_o),
  .pstate_o     (pstate_o),
  .illegal_o    (illegal_o),
  .bank_open_o  (bank_open_o),
  .burst_adv_o  (burst_adv_o)
);

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int SREF = 4;
  localparam int PDN  = 1;

  localparam logic [2:0] K_MRS = 3'd0, K_REF = 3'd1, K_PRE = 3'd2, K_ACT = 3'd3,
                         K_WR  = 3'd4, K_RD  = 3'd5, K_BST = 3'd6, K_NOP = 3'd7;
  localparam int B_NOP = 0, B_MRS = 1, B_ACT = 2, B_RD = 3, B_WR = 4, B_PRE = 5,
                 B_BST = 6, B_REF = 7, B_SREF = 8, B_PDN = 9, B_SUSP = 10,
                 B_EXIT = 11, B_HOLD = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic clk_en = 1'b0, chip_sel_n = 1'b1;
  logic row_strobe_n = 1'b1, col_strobe_n = 1'b1, write_en_n = 1'b1;
  logic [1:0] bank_i = '0;
  logic ap_flag_i = 1'b0, wr_mode_bit_i = 1'b0, burst_adv_i = 1'b0;
  logic [12:0] cmd_o;
  logic [1:0]  pstate_o;
  logic        illegal_o;
  logic [NB-1:0] bank_open_o;
  logic        rd_burst_wr_single_o, burst_adv_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .SREF_EXIT_CYC(SREF), .PDN_EXIT_CYC(PDN)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .write_en_n(write_en_n),
    .bank_i(bank_i), .ap_flag_i(ap_flag_i), .wr_mode_bit_i(wr_mode_bit_i),
    .burst_adv_i(burst_adv_i), .cmd_o(cmd_o), .pstate_o(pstate_o), .illegal_o(illegal_o),
    .bank_open_o(bank_open_o), .rd_burst_wr_single_o(rd_burst_wr_single_o),
    .burst_adv_o(burst_adv_o)
  );

  task automatic issue(input logic ce, input logic cs, input logic [2:0] op,
                       input logic [1:0] ba, input logic ap, input logic mb);
    @(negedge clk);
    clk_en = ce; chip_sel_n = cs; {row_strobe_n, col_strobe_n, write_en_n} = op;
    bank_i = ba; ap_flag_i = ap; wr_mode_bit_i = mb;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // R13: exactly one command bit or the flag
  task automatic want(input string tag, input int b, input logic bad);
    logic [12:0] e;
    e = bad ? 13'd0 : (13'd1 << b);
    n_chk++;
    if (cmd_o !== e || illegal_o !== bad) begin
      n_bad++;
      $display("FAIL %s cmd=%b ill=%b expected cmd=%b ill=%b", tag, cmd_o, illegal_o, e, bad);
    end
  endtask

  function automatic int bit_of(input logic cs, input logic [2:0] op);
    if (cs || op == K_NOP) return B_NOP;
    case (op)
      K_MRS: return B_MRS;
      K_REF: return B_REF;
      K_PRE: return B_PRE;
      K_ACT: return B_ACT;
      K_WR:  return B_WR;
      K_RD:  return B_RD;
      default: return B_BST;
    endcase
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    want("R1 reset cmd", B_NOP, 1'b0);
    chk("R1 reset state", pstate_o, 0);
    chk("R1 reset banks", bank_open_o, 0);
    chk("R1 reset mode", rd_burst_wr_single_o, 0);
    chk("R1 reset adv", burst_adv_o, 0);
    @(negedge clk); rst = 1'b0;
    // R4: previous enable still low after reset
    issue(1, 0, K_ACT, 0, 0, 0);
    want("R4 hold after reset", B_HOLD, 1'b0);
    chk("R4 no bank opened", bank_open_o, 0);
    issue(1, 0, K_NOP, 0, 0, 0);
    want("R2 nop", B_NOP, 1'b0);

    // R2 R3 R10 R11 sweep, banks closed
    for (int cs = 0; cs < 2; cs++)
      for (int op = 0; op < 8; op++)
        for (int mb = 0; mb < 2; mb++) begin
          logic q, bad;
          q   = (cs == 1) || (op == 7);
          bad = !q && (op == K_WR || op == K_RD);
          issue(1, cs[0], op[2:0], 1, 0, mb[0]);
          want(bad ? "R10 rw closed bank" : (cs == 1 ? "R3 deselect" : "R2 decode"),
               bit_of(cs[0], op[2:0]), bad);
          if (!q && op == K_MRS) chk("R11 mode flag", rd_burst_wr_single_o, mb);
          if (!q && op == K_ACT) begin
            chk("R9 act opens", bank_open_o, 4'b0010);
            issue(1, 0, K_PRE, 3, 1, 0);
            chk("R9 precharge all", bank_open_o, 0);
          end
        end

    // R10 sweep with bank 2 open
    issue(1, 0, K_ACT, 2, 0, 0);
    chk("R9 act bank2", bank_open_o, 4'b0100);
    for (int cs = 0; cs < 2; cs++)
      for (int op = 0; op < 8; op++) begin
        logic q, bad;
        q   = (cs == 1) || (op == 7);
        bad = !q && (op == K_MRS || op == K_REF || op == K_ACT);
        issue(1, cs[0], op[2:0], 2, 0, 1);
        want(bad ? "R10 illegal open" : "R2 decode open", bit_of(cs[0], op[2:0]), bad);
        if (bad) begin
          chk("R10 banks unchanged", bank_open_o, 4'b0100);
          chk("R10 mode unchanged", rd_burst_wr_single_o, 1);
        end
        if (!q && op == K_PRE) begin
          chk("R9 single precharge", bank_open_o, 0);
          issue(1, 0, K_ACT, 2, 0, 0);
        end
      end
    issue(1, 0, K_RD, 2, 1, 0);
    want("R9 read autoprecharge", B_RD, 1'b0);
    chk("R9 autoprecharge closes", bank_open_o, 0);

    // power-down entry, wrong exit, exit, window
    issue(0, 1, K_NOP, 0, 0, 0);
    want("R6 pdn entry", B_PDN, 1'b0);
    chk("R6 pdn state", pstate_o, 1);
    issue(0, 0, K_NOP, 0, 0, 0);
    want("R7 hold low", B_HOLD, 1'b0);
    issue(1, 0, K_ACT, 0, 0, 0);
    want("R7 bad exit", 0, 1'b1);
    chk("R7 stays pdn", pstate_o, 1);
    issue(1, 0, K_NOP, 0, 0, 0);
    want("R7 exit", B_EXIT, 1'b0);
    chk("R7 normal", pstate_o, 0);
    issue(1, 0, K_ACT, 0, 0, 0);
    want("R8 pdn window", 0, 1'b1);
    chk("R8 no effect", bank_open_o, 0);
    issue(1, 0, K_ACT, 0, 0, 0);
    want("R8 after window", B_ACT, 1'b0);

    // suspend and burst-advance freeze
    burst_adv_i = 1'b1;
    issue(1, 0, K_NOP, 0, 0, 0);
    chk("R12 adv passes", burst_adv_o, 1);
    issue(0, 0, K_NOP, 0, 0, 0);
    want("R6 suspend entry", B_SUSP, 1'b0);
    chk("R6 suspend state", pstate_o, 2);
    chk("R12 adv frozen", burst_adv_o, 0);
    issue(0, 0, K_NOP, 0, 0, 0);
    chk("R12 adv still frozen", burst_adv_o, 0);
    issue(1, 0, K_NOP, 0, 0, 0);
    want("R7 suspend exit", B_EXIT, 1'b0);
    chk("R12 adv resumes", burst_adv_o, 1);
    burst_adv_i = 1'b0;
    issue(1, 0, K_RD, 0, 1, 0);
    want("R8 no suspend window", B_RD, 1'b0);
    chk("R9 rd autoprecharge", bank_open_o, 0);
    issue(1, 0, K_ACT, 1, 0, 0);
    issue(0, 0, K_WR, 1, 0, 0);
    want("R6 suspend on command", B_SUSP, 1'b0);
    issue(1, 0, K_NOP, 0, 0, 0);
    issue(1, 0, K_PRE, 0, 1, 0);
    issue(0, 0, K_WR, 1, 0, 0);
    want("R6 fall idle with command", 0, 1'b1);
    chk("R6 stays normal", pstate_o, 0);
    issue(1, 0, K_NOP, 0, 0, 0);
    want("R4 hold prev low", B_HOLD, 1'b0);

    // self refresh
    issue(1, 0, K_ACT, 3, 0, 0);
    issue(0, 0, K_REF, 0, 0, 0);
    want("R5 sref with open bank", 0, 1'b1);
    chk("R5 bank kept", bank_open_o, 4'b1000);
    issue(1, 0, K_NOP, 0, 0, 0);
    issue(1, 0, K_PRE, 0, 1, 0);
    issue(0, 0, K_REF, 0, 0, 0);
    want("R5 sref entry", B_SREF, 1'b0);
    chk("R5 sref state", pstate_o, 3);
    issue(0, 1, K_NOP, 0, 0, 0);
    want("R7 sref hold", B_HOLD, 1'b0);
    issue(1, 1, K_ACT, 0, 0, 0);
    want("R7 sref exit deselect", B_EXIT, 1'b0);
    for (int i = 0; i < SREF; i++) begin
      issue(1, 0, K_ACT, 0, 0, 0);
      want("R8 sref window", 0, 1'b1);
    end
    issue(1, 0, K_ACT, 0, 0, 0);
    want("R8 sref window over", B_ACT, 1'b0);
    issue(1, 0, K_PRE, 0, 1, 0);
    issue(0, 0, K_REF, 0, 0, 0);
    issue(1, 0, K_NOP, 0, 0, 0);
    want("R7 sref exit nop", B_EXIT, 1'b0);
    for (int i = 0; i < SREF; i++) begin
      issue(1, 0, K_NOP, 0, 0, 0);
      want("R8 nop in window", B_NOP, 1'b0);
    end
    issue(1, 0, K_REF, 0, 0, 0);
    want("R2 refresh after window", B_REF, 1'b0);

    // R12 pass-through pattern
    for (int i = 0; i < 8; i++) begin
      logic a;
      a = i[0] ^ i[1];
      burst_adv_i = a;
      issue(1, 0, K_NOP, 0, 0, 0);
      chk("R12 adv lag", burst_adv_o, a);
    end
    summary();
  end

endmodule